// File: doc/BRIEF.md
# EEPROM Block Write-Protect Guard

This block decides whether a nonvolatile write into a 4096-byte array may proceed. It sits between the command decoder of a serial memory and the array programming logic. For each write request it raises a combinational permit flag in the same cycle. Requests that carry the topmost array address are not array writes: they update a small protection control register, and that register's value is always visible on an output.

The control register holds four fields. A write-enable latch must be set before the array can be written at all. A two-bit block selector marks none, the top quarter, the top half or all of the array as read-only. A hardware-lock enable bit lets the external write-protect pin freeze the selected blocks and the register itself. A production flow can leave the lock enable clear, hold the pin high, program the whole array in place, and then set the lock enable to make the protection permanent while the pin stays high.

Top module: `eewp_guard`

## Requirements
- R1: After reset the control register reads 0x00 and the permit output is low.
- R2: A write to any address other than 0xFFF is refused while the write-enable latch (register bit 1) is clear.
- R3: The block selector (register bits 4:3) protects no addresses for 00, 0xC00–0xFFF for 01, 0x800–0xFFF for 10 and 0x000–0xFFF for 11; a write to a protected address other than 0xFFF is refused.
- R4: A write to 0xFFF whose data leaves the block selector and the lock-enable bit unchanged is accepted even while the latch is clear, unless the hardware lock is active, and it loads the latch from data bit 1.
- R5: A write to 0xFFF that changes the block selector or the lock-enable bit (register bit 7) is refused while the latch is clear, and the register then keeps its value.
- R6: While the lock-enable bit is set and the write-protect pin is high, every write to 0xFFF is refused and the register keeps its value; with the pin low the register is writable again.
- R7: While the lock-enable bit is clear, the write-protect pin has no effect on any write decision.
- R8: The permit output is low whenever no request is asserted, is valid in the cycle the request is asserted, and an accepted register write shows on the register output after the next rising clock edge.
- R9: Register bits 0, 2, 5 and 6 always read 0, and data written to them is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request strobe, one cycle per request |
| wr_addr | input | 12 | Target byte address of the request |
| wr_data | input | 8 | Data byte of the request |
| wp_pin | input | 1 | External write-protect pin, high to protect |
| wr_permit | output | 1 | High when the current request may proceed |
| ctrl_value | output | 8 | Current protection control register image |

## Verification
On every cycle the assertions check that array writes without the latch or into a protected block are refused, that configuration changes without the latch and all register writes under the hardware lock are refused, that the register never moves while locked or without an accepted write, and that the permit stays low with no request. What only the directed scenarios can show is the exact boundary of each protected range, the layout of fields in the readback including the bits that stay zero, and the full flow of programming the array with the pin high before engaging the lock.

// File: rtl/eewp_pkg.sv
package eewp_pkg;

   typedef enum logic [1:0] {
      ZONE_NONE    = 2'b00,
      ZONE_QUARTER = 2'b01,
      ZONE_HALF    = 2'b10,
      ZONE_ALL     = 2'b11
   } zone_sel_e;

   typedef struct packed {
      logic      lock_en;
      zone_sel_e zone;
      logic      wen;
   } wp_ctrl_t;

   localparam wp_ctrl_t CTRL_RESET = '{lock_en: 1'b0, zone: ZONE_NONE, wen: 1'b0};

endpackage

// File: rtl/eewp_zone_decode.sv
module eewp_zone_decode
   import eewp_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   input  zone_sel_e         zone,
   output logic              in_zone
);

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("eewp_zone_decode: ADDR_W must be at least 2");
      end else begin : g_slice
         logic [1:0] top2;
         assign top2 = addr[ADDR_W-1 -: 2];

         always_comb begin
            unique case (zone)
               ZONE_NONE:    in_zone = 1'b0;
               ZONE_QUARTER: in_zone = (top2 == 2'b11);
               ZONE_HALF:    in_zone = top2[1];
               ZONE_ALL:     in_zone = 1'b1;
               default:      in_zone = 1'b1;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/eewp_reg_policy.sv
module eewp_reg_policy
   import eewp_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int WEN_BIT  = 1,
   parameter int ZONE_LSB = 3,
   parameter int LOCK_BIT = 7
) (
   input  wp_ctrl_t          cur,
   input  logic [DATA_W-1:0] data,
   input  logic              hw_lock,
   output wp_ctrl_t          nxt,
   output logic              reg_ok
);

   localparam logic [DATA_W-1:0] FIELD_MASK =
      (DATA_W'(1) << WEN_BIT) | (DATA_W'(3) << ZONE_LSB) | (DATA_W'(1) << LOCK_BIT);

   logic [DATA_W-1:0] kept;
   logic              cfg_change;

   assign kept = data & FIELD_MASK;

   always_comb begin
      nxt.wen     = kept[WEN_BIT];
      nxt.zone    = zone_sel_e'(kept[ZONE_LSB +: 2]);
      nxt.lock_en = kept[LOCK_BIT];
   end

   assign cfg_change = (nxt.zone != cur.zone) || (nxt.lock_en != cur.lock_en);

   // Latch-only updates bypass the latch; any configuration change needs it.
   assign reg_ok = !hw_lock && (!cfg_change || cur.wen);

endmodule

// File: rtl/eewp_ctrl_reg.sv
module eewp_ctrl_reg
   import eewp_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int WEN_BIT  = 1,
   parameter int ZONE_LSB = 3,
   parameter int LOCK_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  wp_ctrl_t          nxt,
   output wp_ctrl_t          q,
   output logic [DATA_W-1:0] image
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= CTRL_RESET;
      else if (load) q <= nxt;
   end

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_img
         if (b == WEN_BIT) begin : g_wen
            assign image[b] = q.wen;
         end else if (b == ZONE_LSB) begin : g_z0
            assign image[b] = q.zone[0];
         end else if (b == ZONE_LSB + 1) begin : g_z1
            assign image[b] = q.zone[1];
         end else if (b == LOCK_BIT) begin : g_lock
            assign image[b] = q.lock_en;
         end else begin : g_zero
            assign image[b] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/eewp_guard.sv
module eewp_guard
   import eewp_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 8,
   parameter int WEN_BIT  = 1,
   parameter int ZONE_LSB = 3,
   parameter int LOCK_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wp_pin,
   output logic              wr_permit,
   output logic [DATA_W-1:0] ctrl_value
);

   localparam logic [ADDR_W-1:0] CTRL_ADDR = {ADDR_W{1'b1}};

   generate
      if (WEN_BIT >= DATA_W || ZONE_LSB + 1 >= DATA_W || LOCK_BIT >= DATA_W) begin : g_bad_pos
         $error("eewp_guard: a control field lies outside DATA_W");
      end
      if (WEN_BIT == LOCK_BIT || WEN_BIT == ZONE_LSB || WEN_BIT == ZONE_LSB + 1 ||
          LOCK_BIT == ZONE_LSB || LOCK_BIT == ZONE_LSB + 1) begin : g_bad_overlap
         $error("eewp_guard: control fields overlap");
      end
   endgenerate

   wp_ctrl_t ctrl_q;
   wp_ctrl_t ctrl_nxt;
   logic     hit_ctrl;
   logic     hw_lock;
   logic     in_zone;
   logic     reg_ok;
   logic     array_ok;
   logic     load;

   assign hit_ctrl = (wr_addr == CTRL_ADDR);
   assign hw_lock  = ctrl_q.lock_en && wp_pin;

   eewp_zone_decode #(.ADDR_W(ADDR_W)) u_zone (
      .addr    (wr_addr),
      .zone    (ctrl_q.zone),
      .in_zone (in_zone)
   );

   eewp_reg_policy #(
      .DATA_W(DATA_W), .WEN_BIT(WEN_BIT), .ZONE_LSB(ZONE_LSB), .LOCK_BIT(LOCK_BIT)
   ) u_policy (
      .cur     (ctrl_q),
      .data    (wr_data),
      .hw_lock (hw_lock),
      .nxt     (ctrl_nxt),
      .reg_ok  (reg_ok)
   );

   assign array_ok  = ctrl_q.wen && !in_zone;
   assign wr_permit = wr_req && (hit_ctrl ? reg_ok : array_ok);
   assign load      = wr_req && hit_ctrl && reg_ok;

   eewp_ctrl_reg #(
      .DATA_W(DATA_W), .WEN_BIT(WEN_BIT), .ZONE_LSB(ZONE_LSB), .LOCK_BIT(LOCK_BIT)
   ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .nxt   (ctrl_nxt),
      .q     (ctrl_q),
      .image (ctrl_value)
   );

endmodule

// File: rtl/eewp_guard_checker.sv
module eewp_guard_checker #(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 8,
   parameter int WEN_BIT  = 1,
   parameter int ZONE_LSB = 3,
   parameter int LOCK_BIT = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_req,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wp_pin,
   input logic              wr_permit,
   input logic [DATA_W-1:0] ctrl_value
);

   localparam logic [DATA_W-1:0] CFG_MASK =
      (DATA_W'(3) << ZONE_LSB) | (DATA_W'(1) << LOCK_BIT);
   localparam logic [DATA_W-1:0] ALL_MASK = CFG_MASK | (DATA_W'(1) << WEN_BIT);

   logic [DATA_W-1:0] cv, dv;
   logic              wen, lock_en, hit, locked, cfg_diff, zone_hit;
   logic [1:0]        zsel, top2;

   assign cv       = ctrl_value & ALL_MASK;
   assign dv       = wr_data & ALL_MASK;
   assign wen      = cv[WEN_BIT];
   assign lock_en  = cv[LOCK_BIT];
   assign zsel     = cv[ZONE_LSB +: 2];
   assign top2     = wr_addr[ADDR_W-1 -: 2];
   assign hit      = (wr_addr == {ADDR_W{1'b1}});
   assign locked   = lock_en && wp_pin;
   assign cfg_diff = ((dv ^ cv) & CFG_MASK) != '0;
   assign zone_hit = (zsel == 2'b11) || (zsel == 2'b10 && top2[1]) ||
                     (zsel == 2'b01 && top2 == 2'b11);

   a_r2_array_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !hit && !wen) |-> !wr_permit);

   a_r3_zone_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !hit && zone_hit) |-> !wr_permit);

   a_r4_latch_only_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && hit && !locked && !cfg_diff) |-> wr_permit);

   a_r5_cfg_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && hit && !wen && cfg_diff) |-> !wr_permit);

   a_r6_lock_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && hit && locked) |-> !wr_permit);

   a_r6_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(ctrl_value));

   a_r8_idle_no_permit: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |-> !wr_permit);

   a_r8_change_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_value) |-> $past(wr_req && wr_permit && hit));

   a_r9_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_value & ~ALL_MASK) == '0);

endmodule

bind eewp_guard eewp_guard_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WEN_BIT(WEN_BIT), .ZONE_LSB(ZONE_LSB), .LOCK_BIT(LOCK_BIT)
) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_req     (wr_req),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .wp_pin     (wp_pin),
   .wr_permit  (wr_permit),
   .ctrl_value (ctrl_value)
);

// File: tb/eewp_guard_bench.sv
`timescale 1ns/1ps
module eewp_guard_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_req = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        wp_pin = 1'b0;
   logic        wr_permit;
   logic [7:0]  ctrl_value;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   eewp_guard u_eewp_guard (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .wp_pin(wp_pin), .wr_permit(wr_permit), .ctrl_value(ctrl_value)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   // One request: drive at negedge, check permit mid-cycle, drop after the edge.
   task automatic write(input logic [11:0] a, input logic [7:0] d, input logic exp_ok,
                        input string req);
      @(negedge clk);
      wr_req = 1'b1; wr_addr = a; wr_data = d;
      #1 check(req, {7'b0, wr_permit}, {7'b0, exp_ok});
      @(negedge clk);
      wr_req = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      check("R1 ctrl after reset", ctrl_value, 8'h00);
      check("R1 permit after reset", {7'b0, wr_permit}, 8'h00);
   endtask

   task automatic t_latch();
      wp_pin = 1'b0;
      write(12'h000, 8'h55, 1'b0, "R2 array write with latch clear");
      write(12'hFFF, 8'h02, 1'b1, "R4 latch set while clear");
      check("R4 latch loaded", ctrl_value, 8'h02);
      write(12'h000, 8'h55, 1'b1, "R2 array write with latch set");
      write(12'hFFF, 8'h00, 1'b1, "R4 latch cleared");
      check("R4 latch now clear", ctrl_value, 8'h00);
      write(12'h123, 8'h55, 1'b0, "R2 array write after clear");
   endtask

   task automatic t_cfg_guard();
      write(12'hFFF, 8'h08, 1'b0, "R5 zone change without latch");
      check("R5 register unchanged", ctrl_value, 8'h00);
      write(12'hFFF, 8'h80, 1'b0, "R5 lock change without latch");
      check("R5 register still unchanged", ctrl_value, 8'h00);
      write(12'hFFF, 8'h02, 1'b1, "R4 set latch");
      write(12'hFFF, 8'h0A, 1'b1, "R5 zone change with latch");
      check("R8 register after accept", ctrl_value, 8'h0A);
   endtask

   task automatic t_zones();
      write(12'hBFF, 8'h00, 1'b1, "R3 quarter below edge");
      write(12'hC00, 8'h00, 1'b0, "R3 quarter at edge");
      write(12'hFFE, 8'h00, 1'b0, "R3 quarter top");
      write(12'hFFF, 8'h12, 1'b1, "R3 select half");
      check("R3 half readback", ctrl_value, 8'h12);
      write(12'h7FF, 8'h00, 1'b1, "R3 half below edge");
      write(12'h800, 8'h00, 1'b0, "R3 half at edge");
      write(12'hFFF, 8'h1A, 1'b1, "R3 select all");
      write(12'h000, 8'h00, 1'b0, "R3 all bottom");
      write(12'hFFF, 8'h02, 1'b1, "R3 select none");
      write(12'hC00, 8'h00, 1'b1, "R3 none upper");
      write(12'hFFE, 8'h00, 1'b1, "R3 none top");
   endtask

   task automatic t_spare_bits();
      write(12'hFFF, 8'h67, 1'b1, "R9 write with spare bits");
      check("R9 spare bits read zero", ctrl_value, 8'h02);
   endtask

   task automatic t_pin_inert();
      wp_pin = 1'b1;
      write(12'h000, 8'h00, 1'b1, "R7 pin high bottom");
      write(12'hFFE, 8'h00, 1'b1, "R7 pin high top");
      write(12'hFFF, 8'h1A, 1'b1, "R7 register with pin high");
      check("R7 register loaded", ctrl_value, 8'h1A);
      write(12'hFFF, 8'h02, 1'b1, "R7 register restore");
      wp_pin = 1'b0;
   endtask

   task automatic t_hw_lock();
      write(12'hFFF, 8'h8A, 1'b1, "R6 enable lock with pin low");
      check("R6 lock readback", ctrl_value, 8'h8A);
      wp_pin = 1'b1;
      write(12'hFFF, 8'h88, 1'b0, "R6 latch-only under lock");
      write(12'hFFF, 8'h82, 1'b0, "R6 cfg change under lock");
      check("R6 register frozen", ctrl_value, 8'h8A);
      write(12'h000, 8'h00, 1'b1, "R6 unprotected array under lock");
      write(12'hC00, 8'h00, 1'b0, "R6 protected array under lock");
      wp_pin = 1'b0;
      write(12'hFFF, 8'h02, 1'b1, "R6 pin low unlocks");
      check("R6 register after unlock", ctrl_value, 8'h02);
   endtask

   task automatic t_idle();
      @(negedge clk);
      wr_req = 1'b0; wr_addr = 12'h000;
      #1 check("R8 no permit without request", {7'b0, wr_permit}, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_latch();
      t_cfg_guard();
      t_zones();
      t_spare_bits();
      t_pin_inert();
      t_hw_lock();
      t_idle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule